// File: doc/BRIEF.md
# Accumulator ALU with Carry and Zero Flags

This block is the arithmetic and logic stage of a small accumulator machine. An instruction byte is decoded here. The top five bits name the operation. For the data operations, the low three bits are the register index that the surrounding core has already used to fetch the operand. The block takes that operand value, the accumulator value and its own carry flag. It produces the byte to be written back into the accumulator, a write strobe for the accumulator, and the carry and zero flags, which it keeps in registers.

The operations are evaluated in a single combinational pass. The flag pair is updated on the clock edge of each cycle in which the core marks the instruction as executing. Besides the twelve accumulator-writing operations, the block also handles three flag-only instructions: compare, set carry and clear carry. The register file, instruction fetch and memory belong to the surrounding core.

Top module: `acc_alu`

## Requirements
- R1: While `rst_n` is low, and after it rises until the first executed instruction, `carry` and `zero` read 0.
- R2: Field `instr[7:3]` = 00010 writes R+A+carry into A, and = 00011 writes R+1 into A. In both cases the new carry is the carry out of bit 7.
- R3: Field 00100 writes R-A-carry into A, and field 00101 writes R-1 into A, both modulo 256. The new carry is 1 exactly when the true difference is negative (borrow).
- R4: Fields 00110 (NOT R), 00111 (R XOR A), 01000 (R AND A) and 01001 (R OR A) write their result into A and leave carry unchanged.
- R5: Field 01010 writes {R[6:0], carry} into A with new carry R[7]. Field 01011 writes {carry, R[7:1]} into A with new carry R[0].
- R6: Field 01100 writes {R[6:0], R[7]} into A with new carry R[7]. Field 01101 writes {R[0], R[7:1]} into A with new carry R[0].
- R7: After any accumulator-writing operation, `zero` is 1 exactly when the byte written was 00h.
- R8: Field 01110 (compare) does not write A. It sets zero when A equals R and carry when A is strictly greater than R.
- R9: Instruction byte 0Ch sets carry and byte 0Dh clears it. Neither writes A or changes zero.
- R10: In a cycle with `exec` low, `acc_we` is low and both flags hold their values.
- R11: Any other instruction byte, for example 00h, 01h, 02h, 0Ah or anything from 78h upward, leaves `acc_we` low and both flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; flags update on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the flags |
| exec | input | 1 | The instruction on `instr` executes in this cycle |
| instr | input | 8 | Instruction byte; [7:3] operation, [2:0] register index |
| reg_val | input | 8 | Value of the register selected by `instr[2:0]` |
| acc_val | input | 8 | Current accumulator value |
| result | output | 8 | Byte to write into the accumulator |
| acc_we | output | 1 | Accumulator write strobe |
| carry | output | 1 | Registered carry flag |
| zero | output | 1 | Registered zero flag |

## Verification
The bench sweeps each operation over operand grids that include 00h, FFh, 7Fh and 80h, with the carry flag in both states. This exposes a design that drops the carry-in on add or subtract, sets carry for a difference of exactly zero, or fills a shift from the wrong end. Compare is exercised with equal operands and with each operand the larger, to catch a reversed or non-strict greater-than test and any write into A. The logic operations are run with carry set to show that they keep it. Idle cycles and unused opcodes are sent after flags were set, so a design that updates flags on them shows a changed flag at the next sample.

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         exec,
  input  logic [7:0]   instr,
  input  logic [W-1:0] reg_val,
  input  logic [W-1:0] acc_val,
  output logic [W-1:0] result,
  output logic         acc_we,
  output logic         carry,
  output logic         zero
);
  localparam logic [4:0] OP_FLAG = 5'b00001;
  localparam logic [4:0] OP_ADC  = 5'b00010;
  localparam logic [4:0] OP_INC  = 5'b00011;
  localparam logic [4:0] OP_SBC  = 5'b00100;
  localparam logic [4:0] OP_DEC  = 5'b00101;
  localparam logic [4:0] OP_NOT  = 5'b00110;
  localparam logic [4:0] OP_XOR  = 5'b00111;
  localparam logic [4:0] OP_AND  = 5'b01000;
  localparam logic [4:0] OP_OR   = 5'b01001;
  localparam logic [4:0] OP_SLC  = 5'b01010;
  localparam logic [4:0] OP_SRC  = 5'b01011;
  localparam logic [4:0] OP_ROL  = 5'b01100;
  localparam logic [4:0] OP_ROR  = 5'b01101;
  localparam logic [4:0] OP_CMP  = 5'b01110;
  localparam logic [2:0] SUB_SEC = 3'b100;
  localparam logic [2:0] SUB_CLC = 3'b101;

  logic [4:0] op;
  logic [2:0] sub;
  logic [W:0] ext;
  logic       writes, c_nxt, z_nxt;

  assign op  = instr[7:3];
  assign sub = instr[2:0];

  always_comb begin
    ext    = '0;
    result = '0;
    writes = 1'b1;
    c_nxt  = carry;
    z_nxt  = zero;
    case (op)
      OP_ADC: begin
        ext   = {1'b0, reg_val} + {1'b0, acc_val} + {{W{1'b0}}, carry};
        c_nxt = ext[W];
      end
      OP_INC: begin
        ext   = {1'b0, reg_val} + {{W{1'b0}}, 1'b1};
        c_nxt = ext[W];
      end
      OP_SBC: begin
        ext   = {1'b0, reg_val} - {1'b0, acc_val} - {{W{1'b0}}, carry};
        c_nxt = ext[W];
      end
      OP_DEC: begin
        ext   = {1'b0, reg_val} - {{W{1'b0}}, 1'b1};
        c_nxt = ext[W];
      end
      OP_NOT: ext[W-1:0] = ~reg_val;
      OP_XOR: ext[W-1:0] = reg_val ^ acc_val;
      OP_AND: ext[W-1:0] = reg_val & acc_val;
      OP_OR:  ext[W-1:0] = reg_val | acc_val;
      OP_SLC: begin
        ext[W-1:0] = {reg_val[W-2:0], carry};
        c_nxt      = reg_val[W-1];
      end
      OP_SRC: begin
        ext[W-1:0] = {carry, reg_val[W-1:1]};
        c_nxt      = reg_val[0];
      end
      OP_ROL: begin
        ext[W-1:0] = {reg_val[W-2:0], reg_val[W-1]};
        c_nxt      = reg_val[W-1];
      end
      OP_ROR: begin
        ext[W-1:0] = {reg_val[0], reg_val[W-1:1]};
        c_nxt      = reg_val[0];
      end
      OP_CMP: begin
        writes = 1'b0;
        ext    = {1'b0, acc_val} - {1'b0, reg_val};
        z_nxt  = (acc_val == reg_val);
        c_nxt  = (acc_val > reg_val);
      end
      OP_FLAG: begin
        writes = 1'b0;
        if (sub == SUB_SEC) c_nxt = 1'b1;
        else if (sub == SUB_CLC) c_nxt = 1'b0;
      end
      default: writes = 1'b0;
    endcase
    result = ext[W-1:0];
    if (writes) z_nxt = (result == '0);
  end

  assign acc_we = exec && writes;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      carry <= 1'b0;
      zero  <= 1'b0;
    end else if (exec) begin
      carry <= c_nxt;
      zero  <= z_nxt;
    end
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !exec |=> ($stable(carry) && $stable(zero))); // R10
  AST_SEC_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && instr == 8'h0C) |=> (carry && zero == $past(zero))); // R9
  AST_CLC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && instr == 8'h0D) |=> (!carry && zero == $past(zero))); // R9
  AST_LOGIC_KEEPS_C: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && (op == OP_NOT || op == OP_XOR || op == OP_AND || op == OP_OR))
      |=> carry == $past(carry)); // R4
  AST_ZERO_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    acc_we |=> zero == ($past(result) == '0)); // R7
  AST_CMP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && op == OP_CMP) |=> (zero == ($past(acc_val) == $past(reg_val))
                                && carry == ($past(acc_val) > $past(reg_val)))); // R8
  AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && op == OP_CMP) |-> !acc_we); // R8
endmodule

// File: tb/acc_alu_test.sv
module acc_alu_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       exec = 1'b0;
  logic [7:0] instr = 8'h00;
  logic [7:0] reg_val = 8'h00;
  logic [7:0] acc_val = 8'h00;
  logic [7:0] result;
  logic       acc_we, carry, zero;

  int total = 0;
  int bad = 0;
  int mc = 0;
  int mz = 0;
  string flag_tag = "R1";

  always #10 clk = ~clk;

  acc_alu uut (.clk(clk), .rst_n(rst_n), .exec(exec), .instr(instr),
               .reg_val(reg_val), .acc_val(acc_val), .result(result),
               .acc_we(acc_we), .carry(carry), .zero(zero));

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(input int ins, input int e);
    int op = ins / 8;
    if (e == 0) return "R10";
    case (op)
      2, 3: return "R2";
      4, 5: return "R3";
      6, 7, 8, 9: return "R4";
      10, 11: return "R5";
      12, 13: return "R6";
      14: return "R8";
      1: return (ins % 8 == 4 || ins % 8 == 5) ? "R9" : "R11";
      default: return "R11";
    endcase
  endfunction

  task automatic model(input int ins, input int r, input int a,
                       output int we, output int res, output int nc, output int nz);
    int op = ins / 8;
    int s;
    we = 1; res = 0; nc = mc; nz = mz;
    case (op)
      2:  begin s = r + a + mc; res = s % 256; nc = (s > 255); end
      3:  begin s = r + 1; res = s % 256; nc = (s > 255); end
      4:  begin s = r - a - mc; res = (s + 512) % 256; nc = (s < 0); end
      5:  begin s = r - 1; res = (s + 512) % 256; nc = (s < 0); end
      6:  res = 255 - r;
      7:  res = r ^ a;
      8:  res = r & a;
      9:  res = r | a;
      10: begin res = (r * 2 + mc) % 256; nc = (r >= 128); end
      11: begin res = r / 2 + mc * 128; nc = r % 2; end
      12: begin res = (r * 2) % 256 + r / 128; nc = r / 128; end
      13: begin res = r / 2 + (r % 2) * 128; nc = r % 2; end
      14: begin we = 0; nz = (r == a); nc = (a > r); end
      1:  begin
            we = 0;
            if (ins % 8 == 4) nc = 1;
            else if (ins % 8 == 5) nc = 0;
          end
      default: we = 0;
    endcase
    if (we != 0) nz = (res == 0);
  endtask

  task automatic step(input int e, input int ins, input int r, input int a);
    int we, res, nc, nz;
    string tg;
    @(negedge clk);
    chk(flag_tag, "carry", int'(carry), mc);
    chk(flag_tag == "R2" || flag_tag == "R3" || flag_tag == "R4" || flag_tag == "R5"
        || flag_tag == "R6" ? "R7" : flag_tag, "zero", int'(zero), mz);
    exec = e[0]; instr = ins[7:0]; reg_val = r[7:0]; acc_val = a[7:0];
    #2;
    tg = tag_of(ins, e);
    model(ins, r, a, we, res, nc, nz);
    if (e == 0) we = 0;
    chk(tg, "acc_we", int'(acc_we), we);
    if (we != 0) chk(tg, "result", int'(result), res);
    @(posedge clk);
    #1;
    if (e != 0) begin mc = nc; mz = nz; end
    flag_tag = tg;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; exec = 1'b0;
    #3;
    chk("R1", "carry in reset", int'(carry), 0);
    chk("R1", "zero in reset", int'(zero), 0);
    @(negedge clk);
    rst_n = 1'b1;
    mc = 0; mz = 0; flag_tag = "R1";
  endtask

  initial begin
    #(20 * 150000);
    bad++;
    $display("FAIL watchdog run did not finish actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int vals[16];
    vals = '{8'h00, 8'h01, 8'h02, 8'h0F, 8'h10, 8'h3C, 8'h55, 8'h7E,
             8'h7F, 8'h80, 8'h81, 8'hAA, 8'hC3, 8'hF0, 8'hFE, 8'hFF};
    repeat (2) @(negedge clk);
    do_reset();
    step(0, 8'h10, 5, 5);
    // R9 set carry then prove idle and unused codes keep it
    step(1, 8'h0C, 0, 0);
    step(0, 8'h10, 8'hFF, 8'hFF);
    step(0, 8'h0D, 0, 0);
    step(1, 8'h00, 1, 2);
    step(1, 8'h01, 1, 2);
    step(1, 8'h02, 1, 2);
    step(1, 8'h0A, 1, 2);
    step(1, 8'h78, 3, 3);
    step(1, 8'h80, 3, 3);
    step(1, 8'hB3, 3, 3);
    step(1, 8'hC5, 3, 3);
    step(1, 8'hFF, 3, 3);
    // R4 logic ops with carry set
    step(1, 8'h0C, 0, 0);
    step(1, 8'h40, 8'hF0, 8'h0F);
    step(1, 8'h48, 8'h00, 8'h00);
    step(1, 8'h38, 8'h5A, 8'h5A);
    step(1, 8'h30, 8'hFF, 8'h00);
    // R2 R7 wrap to zero with carry out
    step(1, 8'h0C, 0, 0);
    step(1, 8'h10, 8'hFF, 8'h00);
    step(1, 8'h18, 8'hFF, 8'h00);
    // R3 borrow corner and exact zero
    step(1, 8'h0D, 0, 0);
    step(1, 8'h20, 8'h40, 8'h40);
    step(1, 8'h28, 8'h00, 8'h00);
    // R8 compare three ways
    step(1, 8'h70, 8'h33, 8'h33);
    step(1, 8'h70, 8'h34, 8'h33);
    step(1, 8'h70, 8'h32, 8'h33);
    // sweep every operation
    for (int op = 2; op <= 14; op++) begin
      for (int cin = 0; cin < 2; cin++) begin
        for (int i = 0; i < 16; i++) begin
          for (int j = 0; j < 16; j += 3) begin
            step(1, cin != 0 ? 8'h0C : 8'h0D, 0, 0);
            step(1, op * 8 + (i % 8), vals[i], vals[j]);
          end
        end
      end
    end
    // mixed stream
    for (int k = 0; k < 2000; k++) begin
      int ins;
      ins = $urandom % 128;
      step(($urandom % 8) != 0, ins, $urandom % 256, $urandom % 256);
    end
    step(0, 0, 0, 0);
    // R1 reset clears flags set earlier
    step(1, 8'h0C, 0, 0);
    step(1, 8'h70, 8'h09, 8'h09);
    do_reset();
    @(negedge clk);
    chk("R1", "carry after reset", int'(carry), 0);
    chk("R1", "zero after reset", int'(zero), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule